// File: doc/BRIEF.md
# Table-Dispatch Jump Sequencer

This block carries out one fused instruction for a 16-bit CPU: an indirect jump through a 256-entry vector table, indexed by a bytecode. It is meant for the inner loop of a bytecode interpreter. There, the usual sequence of a register load, a shift to a word index, a bank switch, a table load, a bank switch back and a branch becomes one operation that touches memory only twice.

After a start pulse, the sequencer reads the 16-bit source register from memory. The bytecode is in the register's upper byte. The sequencer turns that byte into an even byte offset, between 0 and 510, and keeps it in a private temporary. It then maps the table bank into the low address window and reads the 16-bit vector at table base plus offset. After that it maps the home bank back in. Finally it presents the vector as the new program counter together with a one-cycle done pulse.

Both memory accesses use a request held high until a response arrives. The bank select only moves when no access is in flight. Decoding, the register file and any direct execution of bytecodes belong to the surrounding CPU.

Top module: `tdj_seq`

## Requirements
- R1: After reset, and whenever the unit is idle, `busy_o` is 0, `mem_req_o` is 0, `done_o` is 0 and `bank_sel_o` equals the home bank (0).
- R2: The first memory read of an instruction uses the address `src_addr_i` captured at start, with the home bank (0) selected.
- R3: The second read uses the address `tbl_base_i + 2*B` (modulo 2^16), where B is bits [15:8] of the first read's data. Bits [7:0] of that data have no effect.
- R4: The second read is made with the table bank (1) on `bank_sel_o`.
- R5: Each instruction makes exactly two memory reads, one per response.
- R6: `bank_sel_o` is back to the home bank (0) in the cycle `done_o` is high.
- R7: `done_o` is high for exactly one cycle. In that cycle `new_pc_o` equals the data returned by the second read.
- R8: `bank_sel_o` changes only at an edge where no request was outstanding. It is stable for the whole of each request.
- R9: Each request, with its address, is held until `mem_rvalid_i` is high. With a response latency of L cycles per read, `done_o` is high in cycle 2L+3 after the start edge.
- R10: A start pulse while `busy_o` is high is ignored. It neither changes the addresses used nor starts a further instruction once the current one is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; taken only when idle |
| src_addr_i | input | 16 | Memory address of the source register |
| tbl_base_i | input | 16 | Byte address of the vector table |
| mem_req_o | output | 1 | Read request, held until response |
| mem_addr_o | output | 16 | Read byte address |
| mem_rdata_i | input | 16 | Read data, valid with `mem_rvalid_i` |
| mem_rvalid_i | input | 1 | Read response strobe |
| bank_sel_o | output | 2 | Bank mapped into the low window |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion strobe |
| new_pc_o | output | 16 | Branch target, valid with `done_o` |

## Verification
The start is sampled at one edge, and the first request is visible in the next cycle. Every response is consumed at the edge that ends the cycle in which it is presented, so with per-read latency L the done strobe lands exactly in cycle 2L+3. The bench counts negative edges from the start edge and compares against that figure. Addresses, bank values and read counts are logged by the bench's memory model at the negedge each response is issued, and `new_pc_o` and the bank are sampled at the negedge where `done_o` is first high. The done width and the idle state after an ignored start are checked on the following negedges.

// File: rtl/tdj_pkg.sv
package tdj_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REG,
    ST_BANK_TBL,
    ST_RD_TBL,
    ST_BANK_HOME,
    ST_JUMP
  } tdj_state_e;
endpackage

// File: rtl/tdj_ctrl.sv
module tdj_ctrl
  import tdj_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rvalid_i,
  output logic busy_o,
  output logic req_o,
  output logic sel_tbl_o,
  output logic accept_o,
  output logic reg_cap_o,
  output logic vec_cap_o,
  output logic to_tbl_o,
  output logic to_home_o,
  output logic done_o
);
  tdj_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start_i)  state_d = ST_RD_REG;
      ST_RD_REG:    if (rvalid_i) state_d = ST_BANK_TBL;
      ST_BANK_TBL:                state_d = ST_RD_TBL;
      ST_RD_TBL:    if (rvalid_i) state_d = ST_BANK_HOME;
      ST_BANK_HOME:               state_d = ST_JUMP;
      ST_JUMP:                    state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign req_o     = (state_q == ST_RD_REG) || (state_q == ST_RD_TBL);
  assign sel_tbl_o = (state_q == ST_RD_TBL);
  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign reg_cap_o = (state_q == ST_RD_REG) && rvalid_i;
  assign vec_cap_o = (state_q == ST_RD_TBL) && rvalid_i;
  assign to_tbl_o  = (state_q == ST_BANK_TBL);
  assign to_home_o = (state_q == ST_BANK_HOME);
  assign done_o    = (state_q == ST_JUMP);
endmodule

// File: rtl/tdj_index.sv
module tdj_index #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic [DW-1:0] reg_val_i,
  output logic [AW-1:0] offset_o
);
  // Upper byte times two: shift so the byte's LSB lands on bit 1.
  localparam int SHIFT = DW - 9;
  logic [DW-1:0] shifted;

  always_comb begin
    shifted  = (reg_val_i >> SHIFT) & ~DW'(1);
    offset_o = AW'(shifted);
  end
endmodule

// File: rtl/tdj_bank.sv
module tdj_bank #(
  parameter int BANK_W = 2,
  parameter logic [BANK_W-1:0] HOME_BANK = '0,
  parameter logic [BANK_W-1:0] TBL_BANK  = BANK_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              to_tbl_i,
  input  logic              to_home_i,
  output logic [BANK_W-1:0] bank_o
);
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              bank_en;

  assign bank_en = to_tbl_i || to_home_i;
  assign bank_d  = to_tbl_i ? TBL_BANK : HOME_BANK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= HOME_BANK;
    else if (bank_en) bank_q <= bank_d;
  end

  assign bank_o = bank_q;
endmodule

// File: rtl/tdj_seq.sv
module tdj_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BANK_W = 2,
  parameter logic [BANK_W-1:0] HOME_BANK = '0,
  parameter logic [BANK_W-1:0] TBL_BANK  = BANK_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     src_addr_i,
  input  logic [AW-1:0]     tbl_base_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_rvalid_i,
  output logic [BANK_W-1:0] bank_sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [AW-1:0]     new_pc_o
);
  logic          accept, reg_cap, vec_cap, to_tbl, to_home, sel_tbl;
  logic [AW-1:0] src_q, base_q, tmp_q, vec_q, offset;

  tdj_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rvalid_i  (mem_rvalid_i),
    .busy_o    (busy_o),
    .req_o     (mem_req_o),
    .sel_tbl_o (sel_tbl),
    .accept_o  (accept),
    .reg_cap_o (reg_cap),
    .vec_cap_o (vec_cap),
    .to_tbl_o  (to_tbl),
    .to_home_o (to_home),
    .done_o    (done_o)
  );

  tdj_index #(.DW(DW), .AW(AW)) u_index (
    .reg_val_i (mem_rdata_i),
    .offset_o  (offset)
  );

  tdj_bank #(.BANK_W(BANK_W), .HOME_BANK(HOME_BANK), .TBL_BANK(TBL_BANK)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .to_tbl_i  (to_tbl),
    .to_home_i (to_home),
    .bank_o    (bank_sel_o)
  );

  // Operand latches, loaded once per accepted start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      base_q <= '0;
    end else if (accept) begin
      src_q  <= src_addr_i;
      base_q <= tbl_base_i;
    end
  end

  // Private temporary holding the table offset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmp_q <= '0;
    else if (reg_cap) tmp_q <= offset;
  end

  // Fetched vector.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vec_q <= '0;
    else if (vec_cap) vec_q <= AW'(mem_rdata_i);
  end

  assign mem_addr_o = sel_tbl ? (base_q + tmp_q) : src_q;
  assign new_pc_o   = vec_q;
endmodule

// File: rtl/tdj_seq_chk.sv
module tdj_seq_chk #(
  parameter int AW = 16,
  parameter int BANK_W = 2,
  parameter logic [BANK_W-1:0] HOME_BANK = '0,
  parameter logic [BANK_W-1:0] TBL_BANK  = BANK_W'(1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [AW-1:0]     src_addr_i,
  input logic              mem_req_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic              mem_rvalid_i,
  input logic [BANK_W-1:0] bank_sel_o,
  input logic              busy_o,
  input logic              done_o
);
  logic [1:0]    rd_cnt;
  logic [AW-1:0] src_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt  <= '0;
      src_cap <= '0;
    end else if (start_i && !busy_o) begin
      rd_cnt  <= '0;
      src_cap <= src_addr_i;
    end else if (mem_req_o && mem_rvalid_i && rd_cnt != 2'd3) begin
      rd_cnt  <= rd_cnt + 2'd1;
    end
  end

  AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> (!mem_req_o && !done_o && bank_sel_o == HOME_BANK)); // R1
  AST_FIRST_ADDR:  assert property (@(posedge clk) disable iff (!rst_n) (mem_req_o && rd_cnt == 2'd0) |-> (mem_addr_o == src_cap)); // R2
  AST_FIRST_BANK:  assert property (@(posedge clk) disable iff (!rst_n) (mem_req_o && rd_cnt == 2'd0) |-> (bank_sel_o == HOME_BANK)); // R2
  AST_TABLE_BANK:  assert property (@(posedge clk) disable iff (!rst_n) (mem_req_o && rd_cnt == 2'd1) |-> (bank_sel_o == TBL_BANK)); // R4
  AST_NO_THIRD:    assert property (@(posedge clk) disable iff (!rst_n) mem_req_o |-> (rd_cnt < 2'd2)); // R5
  AST_TWO_READS:   assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (rd_cnt == 2'd2)); // R5
  AST_HOME_DONE:   assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (bank_sel_o == HOME_BANK)); // R6
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R7
  AST_BANK_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) (bank_sel_o != $past(bank_sel_o)) |-> !$past(mem_req_o)); // R8
  AST_REQ_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(bank_sel_o))); // R9
endmodule

bind tdj_seq tdj_seq_chk #(
  .AW(AW), .BANK_W(BANK_W), .HOME_BANK(HOME_BANK), .TBL_BANK(TBL_BANK)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .src_addr_i   (src_addr_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .bank_sel_o   (bank_sel_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/tdj_seq_tb.sv
module tdj_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] src_addr_i = '0;
  logic [15:0] tbl_base_i = '0;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic [15:0] mem_rdata_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic [1:0]  bank_sel_o;
  logic        busy_o;
  logic        done_o;
  logic [15:0] new_pc_o;

  always #4 clk = ~clk; // 125 MHz

  tdj_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .src_addr_i(src_addr_i), .tbl_base_i(tbl_base_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata_i), .mem_rvalid_i(mem_rvalid_i),
    .bank_sel_o(bank_sel_o), .busy_o(busy_o), .done_o(done_o),
    .new_pc_o(new_pc_o)
  );

  int errors = 0;
  int checks = 0;
  int total_cyc = 0;
  bit finished = 0;

  // Memory model state
  int          lat = 1;
  int          wcnt = 0;
  int          rd_n = 0;
  logic [15:0] rd_addr [4];
  logic [1:0]  rd_bank [4];
  logic [15:0] reg_val = '0;

  function automatic logic [15:0] tbl_word(input logic [15:0] a);
    return a * 16'd37 + 16'h1234;
  endfunction

  always @(negedge clk) begin
    if (mem_req_o && !mem_rvalid_i) begin
      wcnt = wcnt + 1;
      if (wcnt == lat) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = (bank_sel_o == 2'd1) ? tbl_word(mem_addr_o) : reg_val;
        if (rd_n < 4) begin
          rd_addr[rd_n] = mem_addr_o;
          rd_bank[rd_n] = bank_sel_o;
        end
        rd_n = rd_n + 1;
      end
    end else begin
      mem_rvalid_i = 1'b0;
      wcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] bc, input logic [7:0] lo,
                        input logic [15:0] src, input logic [15:0] base,
                        input bit poke);
    int cyc;
    int extra_req;
    logic [15:0] taddr;
    taddr   = base + {7'd0, bc, 1'b0};
    reg_val = {bc, lo};
    rd_n    = 0;
    @(negedge clk);
    start_i = 1'b1; src_addr_i = src; tbl_base_i = base;
    @(posedge clk);
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) start_i = 1'b0;
      if (poke && cyc == 2) begin start_i = 1'b1; src_addr_i = src ^ 16'h0F0E; end
      if (poke && cyc == 3) start_i = 1'b0;
      if (done_o || cyc > 60) break;
    end
    chk(cyc == 2*lat + 3, "R9", "done cycle", cyc, 2*lat + 3);
    chk(new_pc_o == tbl_word(taddr), "R7", "new pc", new_pc_o, tbl_word(taddr));
    chk(bank_sel_o == 2'd0, "R6", "bank at done", bank_sel_o, 0);
    chk(rd_n == 2, "R5", "read count", rd_n, 2);
    chk(rd_addr[0] == src, "R2", "first addr", rd_addr[0], src);
    chk(rd_bank[0] == 2'd0, "R2", "first bank", rd_bank[0], 0);
    chk(rd_addr[1] == taddr, "R3", "table addr", rd_addr[1], taddr);
    chk(rd_bank[1] == 2'd1, "R4", "table bank", rd_bank[1], 1);
    @(negedge clk);
    chk(!done_o, "R7", "done width", done_o, 0);
    if (poke) begin
      extra_req = 0;
      for (int k = 0; k < 4; k++) begin
        if (mem_req_o || busy_o) extra_req++;
        @(negedge clk);
      end
      chk(extra_req == 0, "R10", "start while busy ignored", extra_req, 0);
      chk(rd_n == 2, "R10", "no extra reads", rd_n, 2);
    end
  endtask

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", total_cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during and after reset
    chk(!busy_o && !mem_req_o && !done_o, "R1", "idle in reset", {busy_o, mem_req_o, done_o}, 0);
    chk(bank_sel_o == 2'd0, "R1", "bank in reset", bank_sel_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !mem_req_o && !done_o && bank_sel_o == 2'd0, "R1", "idle after reset",
        {busy_o, mem_req_o, done_o, bank_sel_o}, 0);
    for (int l = 1; l <= 3; l++) begin
      lat = l;
      for (int b = 0; b < 256; b++) begin
        logic [15:0] base;
        base = (l == 3) ? 16'hFF80 : 16'h0400 + 16'(l) * 16'h0220;
        run_op(8'(b), 8'(b * 29 + l * 71), 16'h8300 + 16'((b % 16) * 2), base, (b % 8) == 3);
      end
    end
    // R3: same bytecode, every low byte variant gives the same target
    lat = 1;
    for (int lo = 0; lo < 256; lo += 51)
      run_op(8'hA7, 8'(lo), 16'h8320, 16'h1000, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule